// File: doc/BRIEF.md
# Trusted Thread Identifier CSR Unit

This unit holds the identifier of the thread that is currently running, for a core whose program counter carries a capability. Untrusted code can overwrite the general thread pointer register at will. Trusted code therefore needs a source for the thread identity that untrusted code cannot change. This unit provides that source as two CSR views that share one storage register. The privileged view is readable and writable, and the kernel updates it on every context switch. The user view reads the same value but can never write it.

Each cycle the unit decodes one CSR access. The inputs are a 12-bit address, a write flag, the current privilege level and one permission bit taken from the program counter capability that allows access to system registers. For each access the unit returns the read data, an illegal-access flag, and a not-mine flag that tells the rest of the CSR file to handle the access. A parameter selects the capability-width variant, in which the storage also carries a validity tag.

Top module: `tidcsr_unit`

## Requirements
- R1: After reset, both views read back data zero and tag zero.
- R2: A write to address 0x580 is accepted when the privilege code is not 2'b00 (2'b00 is user; 2'b01, 2'b10 and 2'b11 count as supervisor or higher) and the permission bit is 1. It updates the stored value at the next rising clock edge, and a read of 0xC80 in the following cycle returns the new value.
- R3: Any access to 0x580 with privilege code 2'b00 raises the illegal flag and does not change the stored value.
- R4: Any access to 0x580 with the permission bit at 0 raises the illegal flag and does not change the stored value, at every privilege level.
- R5: A read of 0xC80 is legal at every privilege level, whatever the permission bit, and returns the stored value.
- R6: A write to 0xC80 raises the illegal flag at every privilege level and does not change the stored value.
- R7: An access to any address other than 0x580 and 0xC80 raises the not-mine flag, keeps the illegal flag low, returns zero data and does not change the stored value.
- R8: An illegal access returns zero read data and a zero read tag.
- R9: In the capability variant, an accepted write stores the write tag bit, and reads through either view return it.
- R10: With the access-valid input low, all output flags and the read data are zero and the stored value does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | A CSR access is present this cycle |
| acc_addr | input | 12 | CSR address |
| acc_we | input | 1 | Access writes (1) or only reads (0) |
| acc_wdata | input | DATA_W | Write data (CLEN when the capability variant is on, otherwise XLEN) |
| acc_wtag | input | 1 | Write tag bit (capability variant) |
| acc_priv | input | 2 | Current privilege code |
| pcc_sysreg_perm | input | 1 | System-register permission from the program counter capability |
| rd_data | output | DATA_W | Read data |
| rd_tag | output | 1 | Read tag bit |
| acc_illegal | output | 1 | The access is not allowed |
| acc_not_mine | output | 1 | The address belongs to other CSR logic |

## Verification
The only state is the stored identifier and its tag, so a wrong internal state appears on rd_data and rd_tag at the first legal read after the bad edge. A write that is wrongly blocked or wrongly let through shows up one cycle later as a mismatch through the user view. Faults in the permission and privilege decode show at once on the illegal and not-mine flags, in the same cycle as the access.

// File: rtl/tidcsr_pkg.sv
package tidcsr_pkg;
  localparam logic [11:0] ADDR_TID_SUP  = 12'h580;
  localparam logic [11:0] ADDR_TID_USER = 12'hC80;

  typedef enum logic [1:0] {
    PRIV_USER = 2'b00,
    PRIV_SUP  = 2'b01,
    PRIV_HYP  = 2'b10,
    PRIV_MACH = 2'b11
  } priv_e;

  typedef struct packed {
    logic wr_en;
    logic rd_sel;
    logic illegal;
    logic not_mine;
  } acc_dec_t;
endpackage

// File: rtl/tidcsr_rst_sync.sv
module tidcsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/tidcsr_decode.sv
module tidcsr_decode
  import tidcsr_pkg::*;
(
  input  logic       clk,
  input  logic       srst_n,
  input  logic       acc_valid,
  input  logic [11:0] acc_addr,
  input  logic       acc_we,
  input  logic [1:0] acc_priv,
  input  logic       perm,
  output acc_dec_t   dec
);
  logic hit_sup, hit_user, priv_ok, sup_ok;

  always_comb begin
    hit_sup  = acc_valid && (acc_addr == ADDR_TID_SUP);
    hit_user = acc_valid && (acc_addr == ADDR_TID_USER);
    priv_ok  = (acc_priv != PRIV_USER);
    sup_ok   = priv_ok && perm;
    dec.wr_en    = hit_sup && sup_ok && acc_we;
    dec.rd_sel   = (hit_sup && sup_ok) || (hit_user && !acc_we);
    dec.illegal  = (hit_sup && !sup_ok) || (hit_user && acc_we);
    dec.not_mine = acc_valid && !hit_sup && !hit_user;
  end

  // R7
  flags_excl_chk: assert property (@(posedge clk) disable iff (!srst_n)
    dec.not_mine |-> !dec.illegal && !dec.wr_en);
  // R8
  illegal_nowrite_chk: assert property (@(posedge clk) disable iff (!srst_n)
    dec.illegal |-> !dec.wr_en && !dec.rd_sel);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !acc_valid |-> (dec == '0));
endmodule

// File: rtl/tidcsr_store.sv
module tidcsr_store #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wtag,
  output logic [DATA_W-1:0] data_q,
  output logic              tag_q
);
  logic [DATA_W-1:0] data_d;
  logic              tag_d;

  always_comb begin
    data_d = data_q;
    tag_d  = tag_q;
    if (wr_en) begin
      data_d = wdata;
      tag_d  = wtag;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      data_q <= '0;
      tag_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      tag_q  <= tag_d;
    end
  end

  // R3 R4 R6 R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !wr_en |=> $stable(data_q) && $stable(tag_q));
  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!srst_n)
    wr_en |=> (data_q == $past(wdata)));
endmodule

// File: rtl/tidcsr_unit.sv
module tidcsr_unit
  import tidcsr_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int CLEN        = 64,
  parameter bit CAP_VARIANT = 1'b1,
  localparam int DATA_W     = CAP_VARIANT ? CLEN : XLEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [11:0]       acc_addr,
  input  logic              acc_we,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              acc_wtag,
  input  logic [1:0]        acc_priv,
  input  logic              pcc_sysreg_perm,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_tag,
  output logic              acc_illegal,
  output logic              acc_not_mine
);
  logic              srst_n;
  acc_dec_t          dec;
  logic [DATA_W-1:0] tid_q;
  logic              tag_q;
  logic              tag_vis;

  tidcsr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  tidcsr_decode u_dec (
    .clk(clk), .srst_n(srst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_we(acc_we), .acc_priv(acc_priv), .perm(pcc_sysreg_perm), .dec(dec)
  );

  tidcsr_store #(.DATA_W(DATA_W)) u_store (
    .clk(clk), .srst_n(srst_n), .wr_en(dec.wr_en), .wdata(acc_wdata),
    .wtag(acc_wtag), .data_q(tid_q), .tag_q(tag_q)
  );

  generate
    if (CAP_VARIANT) begin : g_cap
      assign tag_vis = tag_q;
    end else begin : g_plain
      assign tag_vis = 1'b0;
    end
  endgenerate

  always_comb begin
    rd_data      = dec.rd_sel ? tid_q : '0;
    rd_tag       = dec.rd_sel && tag_vis;
    acc_illegal  = dec.illegal;
    acc_not_mine = dec.not_mine;
  end

  // R1
  reset_tag_clear_chk: assert property (@(posedge clk)
    !srst_n |-> !tag_q && (tid_q == '0));
  // R5
  user_read_mirror_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (acc_valid && acc_addr == ADDR_TID_USER && !acc_we) |-> (rd_data == tid_q) && !acc_illegal);
endmodule

// File: tb/tidcsr_unit_tb_top.sv
module tidcsr_unit_tb_top;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0;
  logic [11:0]   acc_addr = '0;
  logic          acc_we = 1'b0;
  logic [DW-1:0] acc_wdata = '0;
  logic          acc_wtag = 1'b0;
  logic [1:0]    acc_priv = 2'b00;
  logic          perm = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_tag, acc_illegal, acc_not_mine;

  int n_checks = 0;
  int n_errors = 0;
  logic [DW-1:0] exp_data = '0;
  logic          exp_tag = 1'b0;
  logic [DW-1:0] s_data;
  logic          s_tag, s_ill, s_nm;

  always #2 clk = ~clk;

  tidcsr_unit #(.XLEN(32), .CLEN(64), .CAP_VARIANT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_we(acc_we), .acc_wdata(acc_wdata), .acc_wtag(acc_wtag),
    .acc_priv(acc_priv), .pcc_sysreg_perm(perm), .rd_data(rd_data),
    .rd_tag(rd_tag), .acc_illegal(acc_illegal), .acc_not_mine(acc_not_mine)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access: drive at negedge, sample 1 ns later, commit at next posedge
  task automatic access(input logic [11:0] a, input logic we, input logic [DW-1:0] wd,
                        input logic wt, input logic [1:0] pv, input logic pm);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_we = we; acc_wdata = wd;
    acc_wtag = wt; acc_priv = pv; perm = pm;
    #1;
    s_data = rd_data; s_tag = rd_tag; s_ill = acc_illegal; s_nm = acc_not_mine;
    @(negedge clk);
    acc_valid = 1'b0; acc_we = 1'b0;
  endtask

  task automatic read_user(input string req);
    access(12'hC80, 1'b0, '0, 1'b0, 2'b00, 1'b0);
    chk(req, s_data, exp_data);
    chk(req, {63'd0, s_tag}, {63'd0, exp_tag});
  endtask

  task automatic t_reset;
    read_user("R1");
    access(12'h580, 1'b0, '0, 1'b0, 2'b01, 1'b1);
    chk("R1", s_data, '0);
    chk("R1", {63'd0, s_tag}, '0);
  endtask

  task automatic t_legal_write;
    access(12'h580, 1'b1, 64'hDEAD_BEEF_0123_4567, 1'b1, 2'b01, 1'b1);
    chk("R2", {63'd0, s_ill}, '0);
    exp_data = 64'hDEAD_BEEF_0123_4567; exp_tag = 1'b1;
    read_user("R2");
    access(12'h580, 1'b1, 64'h0000_0000_0000_00A5, 1'b0, 2'b11, 1'b1);
    exp_data = 64'hA5; exp_tag = 1'b0;
    read_user("R2");
    access(12'h580, 1'b1, 64'h1111_2222_3333_4444, 1'b1, 2'b10, 1'b1);
    exp_data = 64'h1111_2222_3333_4444; exp_tag = 1'b1;
    read_user("R2");
  endtask

  task automatic t_user_sup;
    access(12'h580, 1'b1, 64'hFFFF, 1'b0, 2'b00, 1'b1);
    chk("R3", {63'd0, s_ill}, 64'd1);
    chk("R8", s_data, '0);
    read_user("R3");
    access(12'h580, 1'b0, '0, 1'b0, 2'b00, 1'b1);
    chk("R3", {63'd0, s_ill}, 64'd1);
  endtask

  task automatic t_noperm;
    access(12'h580, 1'b1, 64'h5555, 1'b0, 2'b11, 1'b0);
    chk("R4", {63'd0, s_ill}, 64'd1);
    chk("R8", {63'd0, s_tag}, '0);
    read_user("R4");
    access(12'h580, 1'b0, '0, 1'b0, 2'b01, 1'b0);
    chk("R4", {63'd0, s_ill}, 64'd1);
    chk("R8", s_data, '0);
  endtask

  task automatic t_user_read;
    for (int p = 0; p < 4; p++) begin
      access(12'hC80, 1'b0, '0, 1'b0, p[1:0], p[0]);
      chk("R5", s_data, exp_data);
      chk("R5", {63'd0, s_ill}, '0);
    end
  endtask

  task automatic t_user_write;
    access(12'hC80, 1'b1, 64'h7777, 1'b0, 2'b11, 1'b1);
    chk("R6", {63'd0, s_ill}, 64'd1);
    chk("R8", s_data, '0);
    access(12'hC80, 1'b1, 64'h8888, 1'b0, 2'b00, 1'b0);
    chk("R6", {63'd0, s_ill}, 64'd1);
    read_user("R6");
  endtask

  task automatic t_other;
    access(12'h581, 1'b1, 64'h9999, 1'b0, 2'b11, 1'b1);
    chk("R7", {62'd0, s_nm, s_ill}, 64'd2);
    chk("R7", s_data, '0);
    access(12'hC81, 1'b0, '0, 1'b0, 2'b00, 1'b0);
    chk("R7", {62'd0, s_nm, s_ill}, 64'd2);
    read_user("R7");
  endtask

  task automatic t_tag;
    access(12'h580, 1'b1, 64'hCAFE, 1'b1, 2'b01, 1'b1);
    exp_data = 64'hCAFE; exp_tag = 1'b1;
    access(12'h580, 1'b0, '0, 1'b0, 2'b01, 1'b1);
    chk("R9", {63'd0, s_tag}, 64'd1);
    read_user("R9");
  endtask

  task automatic t_idle;
    @(negedge clk);
    acc_valid = 1'b0; acc_addr = 12'h580; acc_we = 1'b1; acc_wdata = 64'h1234;
    acc_priv = 2'b11; perm = 1'b1;
    #1;
    chk("R10", {rd_data[61:0], rd_tag, acc_illegal | acc_not_mine}, '0);
    @(negedge clk);
    acc_we = 1'b0;
    read_user("R10");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    t_reset();
    t_legal_write();
    t_user_sup();
    t_noperm();
    t_user_read();
    t_user_write();
    t_other();
    t_tag();
    t_idle();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #20000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule